// File: doc/BRIEF.md
# Nibble-bus memory cycle target

This block is the target side of a four-bit multiplexed host bus. It runs on the bus clock and watches an active-low frame strobe and four address/data lines. From these it decodes single-byte memory transfers of two kinds: generic memory cycles, which are claimed through an address window, and firmware-space cycles, which are claimed through a four-bit device strap. Once it claims a cycle, it hands the byte to a simple request/acknowledge memory port. It then answers on the bus with sync nibbles, read data and a turnaround.

Cycles it does not claim pass by without effect. The host can cut any cycle short by pulling the strobe low again. A standby flag shows that the bus is idle and no transfer is pending.

Top module: `lpc_mem_target`

## Requirements
- R1: After a synchronous active-low reset, `standby` is 1, `lad_oe` is 0 and `mem_req` is 0.
- R2: The opening code of a cycle is the `lad_in` value on the last clock edge at which `lframe_n` is low. Earlier low-strobe nibbles are overwritten.
- R3: Opening code 0000 starts a generic memory cycle. The next nibble must be 0100 (read) or 0110 (write). Eight address nibbles follow, most significant first. Any other type nibble makes the block ignore the cycle.
- R4: A generic cycle is claimed only if address bits [31:24] equal `WIN_BASE` (default 8'hFF, with `WIN_W`=8). Otherwise the cycle is ignored.
- R5: Opening code 1101 is a firmware read and 1110 a firmware write. The next nibble must equal `dev_id`. Seven address nibbles follow, most significant first, then a size nibble that must be 0000. Any mismatch means the cycle is ignored.
- R6: A claimed write takes two data nibbles, low nibble first, then two host turnaround clocks. It raises `mem_req` with `mem_we`=1, `mem_addr` equal to the low `MEM_AW` address bits, and `mem_wdata` equal to the byte.
- R7: A claimed read raises `mem_req` with `mem_we`=0. It drives sync 0000 and then the byte returned with `mem_ack`, low nibble first.
- R8: Sync begins on the third clock after the last address, size or data nibble. Before the edge that samples `mem_ack` high, every sync clock drives 0101. On the first sync clock after that edge, the block drives 0000.
- R9: After the read data, or after the sync of a write, the block drives 1111 for one clock, releases `lad_oe` on the next clock, and then returns to idle.
- R10: For an ignored cycle, `lad_oe` stays 0 and no memory request is made. Any opening code other than 0000, 1101 or 1110 is ignored.
- R11: `lframe_n` low at any clock edge aborts the cycle in progress. From the next clock, `lad_oe` and `mem_req` are 0, and the block captures a new opening code.
- R12: `standby` is 1 exactly when `lframe_n` is high, the block is idle, and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lframe_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble lines as seen at the pins |
| lad_out | output | 4 | Nibble the block drives back |
| lad_oe | output | 1 | Output enable for `lad_out` |
| dev_id | input | 4 | Device select strap for firmware cycles |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write request |
| mem_addr | output | MEM_AW | Byte address toward memory |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |
| standby | output | 1 | Bus idle and nothing pending |

## Verification
Each bus response is due at a fixed clock after the last host nibble: sync on the third clock, read data on the two clocks after the ready sync, the 1111 nibble after that, and the release one clock later. The number of wait syncs is exactly one less than the memory model's extra latency in clocks (never below zero). The bench drives every nibble on a falling edge and samples every output on a later falling edge, walking the response one clock at a time, so each result is read in the clock where it is due. Ignored cycles are watched over a window of clocks for any driven nibble or request. Aborts are checked one clock after the strobe falls.

// File: rtl/lpc_tgt_pkg.sv
// Shared state encoding and nibble codes for the nibble-bus memory target.
// Assumes a 4-bit bus and single-byte transfers.
package lpc_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_SIZE,
        ST_WDATA,
        ST_HTAR,
        ST_SYNC,
        ST_RDATA,
        ST_TTAR
    } lpc_state_e;

    localparam logic [3:0] OPEN_MEM     = 4'h0;
    localparam logic [3:0] OPEN_FW_RD   = 4'hD;
    localparam logic [3:0] OPEN_FW_WR   = 4'hE;
    localparam logic [3:0] TYPE_MEM_RD  = 4'h4;
    localparam logic [3:0] TYPE_MEM_WR  = 4'h6;
    localparam logic [3:0] SIZE_BYTE    = 4'h0;
    localparam logic [3:0] SYNC_READY   = 4'h0;
    localparam logic [3:0] SYNC_WAIT    = 4'h5;
    localparam logic [3:0] TURN_DRIVE   = 4'hF;

endpackage

// File: rtl/lpc_frame_fsm.sv
// Cycle sequencer: captures the opening code, qualifies the cycle kind,
// counts address/data/turnaround nibbles and steps through the response.
// Assumes win_hit is valid while the last generic address nibble is on lad_in.
module lpc_frame_fsm
    import lpc_tgt_pkg::*;
#(
    parameter int ADDR_NIBS = 8,
    parameter int FW_NIBS   = 7,
    localparam int CNT_W    = $clog2(ADDR_NIBS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lframe_n,
    input  logic [3:0]       lad_in,
    input  logic [3:0]       dev_id,
    input  logic             win_hit,
    input  logic             mem_done,
    output lpc_state_e       state,
    output logic             is_write,
    output logic             phase,
    output logic             req_start,
    output logic             clr_addr,
    output logic             shift_addr,
    output logic             shift_wdata
);

    logic [3:0]       open_q;
    logic             is_fw;
    logic [CNT_W-1:0] cnt;
    logic             fw_open;
    logic             mem_type_ok;
    logic             last_nib;

    assign fw_open     = (open_q == OPEN_FW_RD) || (open_q == OPEN_FW_WR);
    assign mem_type_ok = (lad_in == TYPE_MEM_RD) || (lad_in == TYPE_MEM_WR);
    assign last_nib    = (cnt == '0);
    assign phase       = cnt[0];

    // Strobes toward the data path and the memory handshake.
    always_comb begin
        clr_addr    = (state == ST_START);
        shift_addr  = lframe_n && (state == ST_ADDR);
        shift_wdata = lframe_n && (state == ST_WDATA);
        req_start   = 1'b0;
        if (lframe_n) begin
            if (state == ST_ADDR && last_nib && !is_fw && win_hit && !is_write)
                req_start = 1'b1;
            if (state == ST_SIZE && lad_in == SIZE_BYTE && !is_write)
                req_start = 1'b1;
            if (state == ST_WDATA && last_nib)
                req_start = 1'b1;
        end
    end

    // State register: abort on a low strobe, otherwise advance per nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            open_q   <= '0;
            is_write <= 1'b0;
            is_fw    <= 1'b0;
            cnt      <= '0;
        end else if (!lframe_n) begin
            state  <= ST_START;
            open_q <= lad_in;
        end else begin
            case (state)
                ST_IDLE: state <= ST_IDLE;
                ST_START: begin
                    state <= ST_IDLE;
                    if (open_q == OPEN_MEM && mem_type_ok) begin
                        state    <= ST_ADDR;
                        is_write <= lad_in[1];
                        is_fw    <= 1'b0;
                        cnt      <= CNT_W'(ADDR_NIBS - 1);
                    end else if (fw_open && lad_in == dev_id) begin
                        state    <= ST_ADDR;
                        is_write <= (open_q == OPEN_FW_WR);
                        is_fw    <= 1'b1;
                        cnt      <= CNT_W'(FW_NIBS - 1);
                    end
                end
                ST_ADDR: begin
                    if (!last_nib) begin
                        cnt <= cnt - 1'b1;
                    end else if (is_fw) begin
                        state <= ST_SIZE;
                    end else if (!win_hit) begin
                        state <= ST_IDLE;
                    end else begin
                        state <= is_write ? ST_WDATA : ST_HTAR;
                        cnt   <= CNT_W'(1);
                    end
                end
                ST_SIZE: begin
                    if (lad_in != SIZE_BYTE) begin
                        state <= ST_IDLE;
                    end else begin
                        state <= is_write ? ST_WDATA : ST_HTAR;
                        cnt   <= CNT_W'(1);
                    end
                end
                ST_WDATA: begin
                    if (last_nib) begin
                        state <= ST_HTAR;
                        cnt   <= CNT_W'(1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HTAR: begin
                    if (last_nib) state <= ST_SYNC;
                    else          cnt   <= cnt - 1'b1;
                end
                ST_SYNC: begin
                    if (mem_done) begin
                        state <= is_write ? ST_TTAR : ST_RDATA;
                        cnt   <= CNT_W'(1);
                    end
                end
                ST_RDATA: begin
                    if (last_nib) begin
                        state <= ST_TTAR;
                        cnt   <= CNT_W'(1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_TTAR: begin
                    if (last_nib) state <= ST_IDLE;
                    else          cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lpc_nibble_path.sv
// Data path: assembles address and write-data nibbles and holds the read byte.
// Assumes the address arrives most significant nibble first and the write
// byte low nibble first. The oldest address nibble drops out of the register.
module lpc_nibble_path #(
    parameter int SHIFT_W = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_addr,
    input  logic               shift_addr,
    input  logic               shift_wdata,
    input  logic               ack_take,
    input  logic [3:0]         lad_in,
    input  logic [7:0]         mem_rdata,
    output logic [SHIFT_W-1:0] addr_q,
    output logic [7:0]         wdata_q,
    output logic [7:0]         rdata_q
);

    // Address shift register, cleared at each opening code.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_addr) addr_q <= '0;
        else if (shift_addr)    addr_q <= {addr_q[SHIFT_W-5:0], lad_in};
    end

    // Write byte: the new nibble enters at the top, so the first ends low.
    always_ff @(posedge clk) begin
        if (!rst_n)           wdata_q <= '0;
        else if (shift_wdata) wdata_q <= {lad_in, wdata_q[7:4]};
    end

    // Read byte captured on the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (ack_take) rdata_q <= mem_rdata;
    end

endmodule

// File: rtl/lpc_mem_handshake.sv
// Request/acknowledge toward memory: raises the request once per claimed
// cycle, holds it until acknowledged, and withdraws it on a host abort.
module lpc_mem_handshake (
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic req_start,
    input  logic mem_ack,
    output logic mem_req,
    output logic mem_done,
    output logic ack_take
);

    assign ack_take = mem_req && mem_ack;

    // Request and completion flags.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            mem_req  <= 1'b0;
            mem_done <= 1'b0;
        end else if (req_start) begin
            mem_req  <= 1'b1;
            mem_done <= 1'b0;
        end else if (ack_take) begin
            mem_req  <= 1'b0;
            mem_done <= 1'b1;
        end
    end

endmodule

// File: rtl/lpc_lad_driver.sv
// Output selection: picks the nibble and enable driven back onto the bus
// from the sequencer state. Purely combinational on registered inputs.
module lpc_lad_driver
    import lpc_tgt_pkg::*;
(
    input  lpc_state_e state,
    input  logic       phase,
    input  logic       mem_done,
    input  logic [7:0] rdata_q,
    output logic [3:0] lad_out,
    output logic       lad_oe
);

    // Drive sync, read nibbles, then one turnaround nibble.
    always_comb begin
        lad_out = '0;
        lad_oe  = 1'b0;
        case (state)
            ST_SYNC: begin
                lad_oe  = 1'b1;
                lad_out = mem_done ? SYNC_READY : SYNC_WAIT;
            end
            ST_RDATA: begin
                lad_oe  = 1'b1;
                lad_out = phase ? rdata_q[3:0] : rdata_q[7:4];
            end
            ST_TTAR: begin
                lad_oe  = phase;
                lad_out = phase ? TURN_DRIVE : 4'h0;
            end
            default: begin
                lad_out = '0;
                lad_oe  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lpc_mem_target.sv
// Top level of the nibble-bus memory target. It ties the sequencer, data
// path, memory handshake and output driver together and decodes the generic
// address window. Assumes WIN_W + MEM_AW <= 28 and a single clock domain.
module lpc_mem_target
    import lpc_tgt_pkg::*;
#(
    parameter int              MEM_AW   = 20,
    parameter int              WIN_W    = 8,
    parameter logic [WIN_W-1:0] WIN_BASE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lframe_n,
    input  logic [3:0]        lad_in,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    input  logic [3:0]        dev_id,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    output logic              standby
);

    localparam int ADDR_NIBS = 8;
    localparam int FW_NIBS   = 7;
    localparam int SHIFT_W   = 4 * ADDR_NIBS - 4;

    lpc_state_e         state;
    logic               phase;
    logic               req_start;
    logic               clr_addr;
    logic               shift_addr;
    logic               shift_wdata;
    logic               mem_done;
    logic               ack_take;
    logic               win_hit;
    logic [SHIFT_W-1:0] addr_q;
    logic [7:0]         rdata_q;

    // While the last address nibble is on the bus, the window bits sit at the top.
    assign win_hit  = (addr_q[SHIFT_W-1 -: WIN_W] == WIN_BASE);
    assign mem_addr = addr_q[MEM_AW-1:0];
    assign standby  = lframe_n && (state == ST_IDLE) && !mem_req;

    lpc_frame_fsm #(
        .ADDR_NIBS (ADDR_NIBS),
        .FW_NIBS   (FW_NIBS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .lframe_n    (lframe_n),
        .lad_in      (lad_in),
        .dev_id      (dev_id),
        .win_hit     (win_hit),
        .mem_done    (mem_done),
        .state       (state),
        .is_write    (mem_we),
        .phase       (phase),
        .req_start   (req_start),
        .clr_addr    (clr_addr),
        .shift_addr  (shift_addr),
        .shift_wdata (shift_wdata)
    );

    lpc_nibble_path #(
        .SHIFT_W (SHIFT_W)
    ) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_addr    (clr_addr),
        .shift_addr  (shift_addr),
        .shift_wdata (shift_wdata),
        .ack_take    (ack_take),
        .lad_in      (lad_in),
        .mem_rdata   (mem_rdata),
        .addr_q      (addr_q),
        .wdata_q     (mem_wdata),
        .rdata_q     (rdata_q)
    );

    lpc_mem_handshake u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (!lframe_n),
        .req_start (req_start),
        .mem_ack   (mem_ack),
        .mem_req   (mem_req),
        .mem_done  (mem_done),
        .ack_take  (ack_take)
    );

    lpc_lad_driver u_drv (
        .state    (state),
        .phase    (phase),
        .mem_done (mem_done),
        .rdata_q  (rdata_q),
        .lad_out  (lad_out),
        .lad_oe   (lad_oe)
    );

endmodule

// File: rtl/lpc_mem_target_chk.sv
// Port-level protocol checker for lpc_mem_target, attached by bind below.
module lpc_mem_target_chk #(
    parameter int MEM_AW = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lframe_n,
    input logic [3:0]        lad_out,
    input logic              lad_oe,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              standby
);

    // R11
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n |=> (!lad_oe && !mem_req));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && lframe_n) |=> (mem_req && $stable(mem_addr)));

    // R7
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    // R8
    first_drive_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lad_oe) |-> (lad_out == 4'h0 || lad_out == 4'h5));

    // R9
    wait_keeps_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lad_oe && lad_out == 4'h5 && lframe_n) |=> lad_oe);

    // R12
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (!lad_oe && !mem_req));

endmodule

bind lpc_mem_target lpc_mem_target_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lframe_n (lframe_n),
    .lad_out  (lad_out),
    .lad_oe   (lad_oe),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .standby  (standby)
);

// File: tb/sim_lpc_mem_target.sv
// Directed bench for lpc_mem_target: one task per scenario, 50 MHz clock.
module sim_lpc_mem_target;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lframe_n;
    logic [3:0]  lad_in;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic [3:0]  dev_id;
    logic        mem_req;
    logic        mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_ack;
    logic        standby;

    int checks = 0;
    int errors = 0;

    // Memory model state
    logic [7:0]  mem [0:255];
    int          lat = 0;
    int          lat_cnt = 0;
    int          wr_count = 0;
    logic [19:0] last_waddr;
    logic [7:0]  last_wdata;

    always #10 clk = ~clk;

    lpc_mem_target u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .lframe_n  (lframe_n),
        .lad_in    (lad_in),
        .lad_out   (lad_out),
        .lad_oe    (lad_oe),
        .dev_id    (dev_id),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .standby   (standby)
    );

    // Memory model: acknowledges after lat extra falling edges.
    always @(negedge clk) begin
        if (!rst_n || !mem_req || mem_ack) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (lat_cnt == lat) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wr_count   <= wr_count + 1;
                last_waddr <= mem_addr;
                last_wdata <= mem_wdata;
            end else begin
                mem_rdata <= mem[mem_addr[7:0]];
            end
        end else begin
            lat_cnt <= lat_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic f, input logic [3:0] n);
        @(negedge clk);
        lframe_n = f;
        lad_in   = n;
    endtask

    // Generic cycle body after the opening code.
    task automatic gen_body(input logic [3:0] typ, input logic [31:0] a, input logic [7:0] d);
        step(1'b1, typ);
        for (int i = 7; i >= 0; i--) step(1'b1, a[i*4 +: 4]);
        if (typ[1]) begin
            step(1'b1, d[3:0]);
            step(1'b1, d[7:4]);
        end
        step(1'b1, 4'hF);
        step(1'b1, 4'hF);
    endtask

    task automatic send_fw(input bit wr, input logic [3:0] id, input logic [27:0] a,
                           input logic [3:0] sz, input logic [7:0] d);
        step(1'b0, wr ? 4'hE : 4'hD);
        step(1'b1, id);
        for (int i = 6; i >= 0; i--) step(1'b1, a[i*4 +: 4]);
        step(1'b1, sz);
        if (wr) begin
            step(1'b1, d[3:0]);
            step(1'b1, d[7:4]);
        end
        step(1'b1, 4'hF);
        step(1'b1, 4'hF);
    endtask

    // Walks the target response clock by clock after the host turnaround.
    task automatic respond(input bit wr, input int exp_waits, input logic [7:0] exp_d, input string tag);
        int waits = 0;
        bit got = 0;
        bit busy = 1;
        logic [7:0] d;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            lad_in = 4'hF;
            if (standby) busy = 0;
            if (lad_oe && lad_out == 4'h0) begin got = 1; break; end
            else if (lad_oe && lad_out == 4'h5) waits++;
            else break;
        end
        chk(got, {tag, " R8 ready sync"}, 32'(got), 1);
        chk(waits == exp_waits, {tag, " R8 wait count"}, waits, exp_waits);
        chk(busy, {tag, " R12 standby low during cycle"}, 32'(busy), 1);
        if (!wr) begin
            @(negedge clk); d[3:0] = lad_out;
            chk(lad_oe, {tag, " R7 low nibble driven"}, 32'(lad_oe), 1);
            @(negedge clk); d[7:4] = lad_out;
            chk(d == exp_d, {tag, " R7 read byte"}, d, exp_d);
        end
        @(negedge clk);
        chk(lad_oe && lad_out == 4'hF, {tag, " R9 turnaround 1111"}, {lad_oe, lad_out}, 5'h1F);
        @(negedge clk);
        chk(!lad_oe, {tag, " R9 release"}, 32'(lad_oe), 0);
        @(negedge clk);
        chk(standby, {tag, " R12 standby after cycle"}, 32'(standby), 1);
    endtask

    task automatic expect_silent(input int n, input string tag);
        int wc = wr_count;
        bit seen = 0;
        repeat (n) begin
            @(negedge clk);
            lad_in = 4'hF;
            if (lad_oe || mem_req) seen = 1;
        end
        chk(!seen, {tag, " R10 bus and memory untouched"}, 32'(seen), 0);
        chk(wr_count == wc, {tag, " R10 no write"}, wr_count, wc);
        chk(standby, {tag, " R12 standby"}, 32'(standby), 1);
    endtask

    task automatic check_write(input int wc0, input logic [19:0] a, input logic [7:0] d, input string tag);
        chk(wr_count == wc0 + 1, {tag, " R6 one write"}, wr_count, wc0 + 1);
        chk(last_waddr == a, {tag, " R6 write address"}, last_waddr, a);
        chk(last_wdata == d, {tag, " R6 write byte"}, last_wdata, d);
    endtask

    task automatic t_reset;
        chk(standby, "R1 standby", 32'(standby), 1);
        chk(!lad_oe, "R1 lad_oe", 32'(lad_oe), 0);
        chk(!mem_req, "R1 mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_mem_write;
        int wc0 = wr_count;
        lat = 0;
        step(1'b0, 4'h0);
        gen_body(4'h6, 32'hFF00_0010, 8'h3C);
        respond(1'b1, 0, 8'h00, "R3 generic write");
        check_write(wc0, 20'h00010, 8'h3C, "R3 generic write");
    endtask

    task automatic t_mem_read_fast;
        lat = 0;
        step(1'b0, 4'h0);
        gen_body(4'h4, 32'hFF00_0010, 8'h00);
        respond(1'b0, 0, 8'h3C, "R7 generic read no wait");
    endtask

    task automatic t_mem_read_wait;
        lat = 3;
        step(1'b0, 4'h0);
        gen_body(4'h4, 32'hFF00_0020, 8'h00);
        respond(1'b0, 2, 8'h7A, "R8 generic read three clock latency");
        lat = 0;
    endtask

    task automatic t_fw_write_read;
        int wc0 = wr_count;
        lat = 1;
        send_fw(1'b1, 4'h3, 28'h000_0042, 4'h0, 8'h9C);
        respond(1'b1, 0, 8'h00, "R5 firmware write");
        check_write(wc0, 20'h00042, 8'h9C, "R5 firmware write");
        lat = 2;
        send_fw(1'b0, 4'h3, 28'h000_0042, 4'h0, 8'h00);
        respond(1'b0, 1, 8'h9C, "R5 firmware read");
        lat = 0;
    endtask

    task automatic t_fw_foreign_id;
        send_fw(1'b1, 4'h7, 28'h000_0050, 4'h0, 8'hAA);
        expect_silent(6, "R5 foreign device select");
    endtask

    task automatic t_fw_bad_size;
        send_fw(1'b0, 4'h3, 28'h000_0050, 4'h1, 8'h00);
        expect_silent(6, "R5 size not single byte");
    endtask

    task automatic t_bad_start;
        step(1'b0, 4'h2);
        gen_body(4'h6, 32'hFF00_0060, 8'h11);
        expect_silent(6, "R10 unknown opening code");
    endtask

    task automatic t_out_of_window;
        step(1'b0, 4'h0);
        gen_body(4'h6, 32'h1200_0070, 8'h22);
        expect_silent(6, "R4 write outside window");
        step(1'b0, 4'h0);
        gen_body(4'h4, 32'hFE00_0070, 8'h00);
        expect_silent(6, "R4 read outside window");
    endtask

    task automatic t_bad_type;
        step(1'b0, 4'h0);
        gen_body(4'h2, 32'hFF00_0080, 8'h33);
        expect_silent(6, "R3 non-memory type nibble");
    endtask

    task automatic t_multi_clock_start;
        int wc0 = wr_count;
        step(1'b0, 4'hD);
        step(1'b0, 4'h5);
        step(1'b0, 4'h0);
        gen_body(4'h6, 32'hFF00_0090, 8'h5E);
        respond(1'b1, 0, 8'h00, "R2 last low nibble is code");
        check_write(wc0, 20'h00090, 8'h5E, "R2 last low nibble is code");
        step(1'b0, 4'h0);
        step(1'b0, 4'h5);
        gen_body(4'h6, 32'hFF00_00A0, 8'h66);
        expect_silent(6, "R2 earlier valid nibble overwritten");
    endtask

    task automatic t_abort_address;
        int wc0 = wr_count;
        step(1'b0, 4'h0);
        step(1'b1, 4'h4);
        step(1'b1, 4'hF);
        step(1'b1, 4'hF);
        step(1'b1, 4'h0);
        step(1'b0, 4'h0);
        gen_body(4'h6, 32'hFF00_00B0, 8'hC3);
        respond(1'b1, 0, 8'h00, "R11 abort then new cycle");
        check_write(wc0, 20'h000B0, 8'hC3, "R11 abort then new cycle");
    endtask

    task automatic t_abort_wait;
        lat = 12;
        step(1'b0, 4'h0);
        gen_body(4'h4, 32'hFF00_0030, 8'h00);
        @(negedge clk);
        lad_in = 4'hF;
        chk(lad_oe && lad_out == 4'h5, "R8 wait sync before abort", {lad_oe, lad_out}, 5'h15);
        step(1'b0, 4'hF);
        step(1'b1, 4'hF);
        chk(!lad_oe, "R11 bus released after abort", 32'(lad_oe), 0);
        chk(!mem_req, "R11 request withdrawn", 32'(mem_req), 0);
        @(negedge clk);
        chk(standby, "R12 standby after abort", 32'(standby), 1);
        lat = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        rst_n    = 1'b0;
        lframe_n = 1'b1;
        lad_in   = 4'hF;
        dev_id   = 4'h3;
        mem_ack  = 1'b0;
        mem_rdata = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mem_write();
        t_mem_read_fast();
        t_mem_read_wait();
        t_fw_write_read();
        t_fw_foreign_id();
        t_fw_bad_size();
        t_bad_start();
        t_out_of_window();
        t_bad_type();
        t_multi_clock_start();
        t_abort_address();
        t_abort_wait();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule